// File: doc/BRIEF.md
# Video Sync Source Selector

This block sits in front of the horizontal and vertical counters of a video encoder timing generator. When the encoder follows an external graphics controller, it synchronises the line, field and frame sync pins into the pixel clock domain. It finds the active edge of each pin and turns the chosen edges into single-cycle trigger pulses for the horizontal and vertical state machines. Frame sync can stand in for either of the other two pins, and the horizontal trigger can be timed from the previous line so that it lands a fixed 128 pixel clocks before the next line sync edge is due.

When the encoder generates timing itself, the block turns the counters' internal frame and field pulses into pin drive levels with programmable polarity, and sets each pin's output enable. It also produces a composite-blank output whose sense during active video is selectable. Every setting is held in shadow registers that load only on a frame-start strobe, so a change never takes effect in the middle of a frame.

Top module: `vsync_src_sel`

## Requirements
- R1: With `cfg_slave` at 0 in the loaded settings, `h_trig_o` and `v_trig_o` both stay 0 whatever the sync pins do; with it at 1 the triggers follow the rules below.
- R2: Each sync pin goes through two synchronising flops; if a qualifying pin change is first sampled on clock edge n, the trigger is 1 from edge n+1 to edge n+2 and 0 in the cycles on either side, so every qualifying edge gives exactly one one-cycle pulse.
- R3: The horizontal trigger comes from rising edges of `hs_pin_i`; when both `cfg_h_from_fs` and `cfg_fs_en` are 1 it comes from the active edge of `fs_pin_i` instead, and `hs_pin_i` is then ignored.
- R4: The vertical trigger comes from the active edge of `vs_pin_i`; when both `cfg_v_from_fs` and `cfg_fs_en` are 1 it comes from the active edge of `fs_pin_i` instead.
- R5: `cfg_fs_pol` and `cfg_vs_pol` at 0 select the rising edge of their pin as active and make `fs_pin_o`/`vs_pin_o` equal to `mst_fs_i`/`mst_vs_i`; at 1 they select the falling edge and invert the drive.
- R6: `fs_oe_o` equals `cfg_fs_dir` and `vs_oe_o` equals `cfg_vs_dir`; while a pin's direction bit is 1, edges on that pin's input produce no trigger.
- R7: With `cfg_late_h` and `cfg_slave` at 1, `h_trig_o` no longer follows the edges directly; it fires once, exactly `cfg_line_len - 128` cycles after the cycle in which a selected horizontal edge would have pulsed, and never before the first such edge after reset; an edge that lands in the firing cycle restarts the count without losing that pulse.
- R8: `cblank_o` equals `active_video_i` when `cfg_blank_pol` is 0 and its inverse when it is 1.
- R9: Settings are captured in the first cycle after reset and in every cycle where `frame_start_i` is 1, and take effect in the next cycle; changes at other times have no effect.
- R10: With `cfg_fs_en` at 0, edges on `fs_pin_i` produce no trigger, even when a frame-sync source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave | input | 1 | 1: follow external controller, 0: generate timing |
| cfg_fs_en | input | 1 | Accept frame sync pin in slave mode |
| cfg_h_from_fs | input | 1 | Horizontal trigger source is frame sync |
| cfg_v_from_fs | input | 1 | Vertical trigger source is frame sync |
| cfg_fs_pol | input | 1 | Frame sync polarity (0 rising/high, 1 falling/low) |
| cfg_vs_pol | input | 1 | Field sync polarity (0 rising/high, 1 falling/low) |
| cfg_fs_dir | input | 1 | Frame sync pin direction (1 output) |
| cfg_vs_dir | input | 1 | Field sync pin direction (1 output) |
| cfg_late_h | input | 1 | Advance horizontal trigger by 128 clocks |
| cfg_blank_pol | input | 1 | Composite-blank polarity (1 low in active video) |
| cfg_line_len | input | LINE_W | Line length in pixel clocks for the advanced trigger |
| frame_start_i | input | 1 | Frame boundary strobe that loads the settings |
| hs_pin_i | input | 1 | Line sync pin input |
| vs_pin_i | input | 1 | Field sync pin input |
| fs_pin_i | input | 1 | Frame sync pin input |
| mst_fs_i | input | 1 | Internal frame pulse to drive in master mode |
| mst_vs_i | input | 1 | Internal field pulse to drive in master mode |
| active_video_i | input | 1 | Active video window from the counters |
| h_trig_o | output | 1 | Horizontal state machine trigger pulse |
| v_trig_o | output | 1 | Vertical state machine trigger pulse |
| fs_pin_o | output | 1 | Frame sync pin drive level |
| fs_oe_o | output | 1 | Frame sync pin output enable |
| vs_pin_o | output | 1 | Field sync pin drive level |
| vs_oe_o | output | 1 | Field sync pin output enable |
| cblank_o | output | 1 | Composite-blank output |

## Verification
In the advanced horizontal mode a fresh line sync edge can be detected in the very cycle where the timer from the previous edge fires. The bench provokes this by placing the second rising edge of the line sync pin so that its detection falls exactly twelve cycles after the first with a line length of 140. It then expects one pulse in that shared cycle, none on the cycles around it, and the next pulse twelve cycles later, which shows the timer restarted from the new edge rather than being dropped or doubled.

// File: rtl/vss_pkg.sv
package vss_pkg;

  localparam int NUM_PINS = 3;
  localparam int PIN_HS   = 0;
  localparam int PIN_FS   = 1;
  localparam int PIN_VS   = 2;

  typedef struct packed {
    logic slave;
    logic fs_en;
    logic h_from_fs;
    logic v_from_fs;
    logic fs_pol;
    logic vs_pol;
    logic fs_dir;
    logic vs_dir;
    logic late_h;
    logic blank_pol;
  } vss_cfg_t;

  // active edge seen on a synchronised level pair
  function automatic logic edge_hit(input logic cur, input logic prev, input logic fall);
    return fall ? (prev & ~cur) : (cur & ~prev);
  endfunction

  // frame sync replaces the dedicated pin only when both bits allow it
  function automatic logic pick_src(input logic want_fs, input logic fs_on,
                                    input logic fs_evt, input logic own_evt);
    return (want_fs & fs_on) ? fs_evt : own_evt;
  endfunction

  function automatic logic drive_level(input logic active, input logic pol);
    return active ^ pol;
  endfunction

endpackage

// File: rtl/vss_cfg_shadow.sv
module vss_cfg_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] cfg_d,
  output logic [W-1:0] cfg_q
);
  logic primed;
  logic take;

  assign take = load_i | ~primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      cfg_q  <= '0;
    end else begin
      primed <= 1'b1;
      if (take) cfg_q <= cfg_d;
    end
  end

  // R9: settings only move on a frame boundary once primed
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/vss_sync_edge.sv
module vss_sync_edge import vss_pkg::*; #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_i,
  output logic hit_o
);
  logic [STAGES:0] sh;
  logic cur_lvl;
  logic prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin_i};
  end

  assign cur_lvl  = sh[STAGES-1];
  assign prev_lvl = sh[STAGES];
  assign hit_o    = edge_hit(cur_lvl, prev_lvl, fall_i);

endmodule

// File: rtl/vss_late_timer.sv
module vss_late_timer #(
  parameter int CNT_W   = 12,
  parameter int ADVANCE = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] line_len_i,
  output logic             fire_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] ADV_C   = CNT_W'(ADVANCE);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] fire_point(input logic [CNT_W-1:0] len);
    return len - ADV_C;
  endfunction

  logic [CNT_W-1:0] since_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_edge <= '0;
      armed_o    <= 1'b0;
    end else if (edge_i) begin
      since_edge <= CNT_W'(1);
      armed_o    <= 1'b1;
    end else if (armed_o && since_edge != CNT_MAX) begin
      since_edge <= since_edge + 1'b1;
    end
  end

  assign fire_o = armed_o && (since_edge == fire_point(line_len_i));

  // R7: one advanced pulse per measured line
  a_r7_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && (line_len_i > CNT_W'(ADVANCE + 1)) |=> !fire_o);

endmodule

// File: rtl/vsync_src_sel.sv
module vsync_src_sel import vss_pkg::*; #(
  parameter int LINE_W      = 12,
  parameter int ADVANCE     = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slave,
  input  logic              cfg_fs_en,
  input  logic              cfg_h_from_fs,
  input  logic              cfg_v_from_fs,
  input  logic              cfg_fs_pol,
  input  logic              cfg_vs_pol,
  input  logic              cfg_fs_dir,
  input  logic              cfg_vs_dir,
  input  logic              cfg_late_h,
  input  logic              cfg_blank_pol,
  input  logic [LINE_W-1:0] cfg_line_len,
  input  logic              frame_start_i,
  input  logic              hs_pin_i,
  input  logic              vs_pin_i,
  input  logic              fs_pin_i,
  input  logic              mst_fs_i,
  input  logic              mst_vs_i,
  input  logic              active_video_i,
  output logic              h_trig_o,
  output logic              v_trig_o,
  output logic              fs_pin_o,
  output logic              fs_oe_o,
  output logic              vs_pin_o,
  output logic              vs_oe_o,
  output logic              cblank_o
);
  localparam int FLAG_W = $bits(vss_cfg_t);
  localparam int CFG_W  = FLAG_W + LINE_W;

  vss_cfg_t          cfg_d;
  vss_cfg_t          cfg_q;
  logic [LINE_W-1:0] len_q;
  logic [CFG_W-1:0]  shadow_q;

  assign cfg_d = '{slave:     cfg_slave,
                   fs_en:     cfg_fs_en,
                   h_from_fs: cfg_h_from_fs,
                   v_from_fs: cfg_v_from_fs,
                   fs_pol:    cfg_fs_pol,
                   vs_pol:    cfg_vs_pol,
                   fs_dir:    cfg_fs_dir,
                   vs_dir:    cfg_vs_dir,
                   late_h:    cfg_late_h,
                   blank_pol: cfg_blank_pol};

  vss_cfg_shadow #(.W(CFG_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (frame_start_i),
    .cfg_d  ({cfg_line_len, cfg_d}),
    .cfg_q  (shadow_q)
  );

  assign {len_q, cfg_q} = shadow_q;

  // one synchroniser and edge finder per sync pin
  logic [NUM_PINS-1:0] pin_raw;
  logic [NUM_PINS-1:0] pin_fall;
  logic [NUM_PINS-1:0] pin_hit;

  assign pin_raw  = {vs_pin_i, fs_pin_i, hs_pin_i};
  assign pin_fall = {cfg_q.vs_pol, cfg_q.fs_pol, 1'b0};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    vss_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_raw[i]),
      .fall_i (pin_fall[i]),
      .hit_o  (pin_hit[i])
    );
  end

  // named events for the assertions
  logic hs_evt, fs_evt, vs_evt;
  logic h_evt, v_evt;
  logic late_fire, h_armed;

  assign hs_evt = pin_hit[PIN_HS];
  assign fs_evt = pin_hit[PIN_FS] & cfg_q.fs_en & ~cfg_q.fs_dir;
  assign vs_evt = pin_hit[PIN_VS] & ~cfg_q.vs_dir;

  assign h_evt = pick_src(cfg_q.h_from_fs, cfg_q.fs_en, fs_evt, hs_evt);
  assign v_evt = pick_src(cfg_q.v_from_fs, cfg_q.fs_en, fs_evt, vs_evt);

  vss_late_timer #(.CNT_W(LINE_W), .ADVANCE(ADVANCE)) u_late (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_i     (h_evt),
    .line_len_i (len_q),
    .fire_o     (late_fire),
    .armed_o    (h_armed)
  );

  assign h_trig_o = cfg_q.slave & (cfg_q.late_h ? late_fire : h_evt);
  assign v_trig_o = cfg_q.slave & v_evt;

  // master-side pin drive and blanking
  assign fs_pin_o = drive_level(mst_fs_i, cfg_q.fs_pol);
  assign vs_pin_o = drive_level(mst_vs_i, cfg_q.vs_pol);
  assign fs_oe_o  = cfg_q.fs_dir;
  assign vs_oe_o  = cfg_q.vs_dir;
  assign cblank_o = drive_level(active_video_i, cfg_q.blank_pol);

  // R1: master mode keeps the state machines free of external triggers
  a_r1_master_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.slave |-> !h_trig_o && !v_trig_o);

  // R7: advanced mode issues nothing before the first measured edge
  a_r7_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.late_h && !h_armed |-> !h_trig_o);

  // R10: frame sync is inert while it is not enabled
  a_r10_fs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.fs_en |-> !fs_evt);

  // R3: direct horizontal mode only pulses on a source edge
  a_r3_h_source: assert property (@(posedge clk) disable iff (!rst_n)
    h_trig_o && !cfg_q.late_h |-> (hs_evt || fs_evt));

endmodule

// File: tb/sim_vsync_src_sel.sv
module sim_vsync_src_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_slave = 1'b1, cfg_fs_en = 1'b0, cfg_h_from_fs = 1'b0, cfg_v_from_fs = 1'b0;
  logic cfg_fs_pol = 1'b0, cfg_vs_pol = 1'b0, cfg_fs_dir = 1'b0, cfg_vs_dir = 1'b0;
  logic cfg_late_h = 1'b0, cfg_blank_pol = 1'b0;
  logic [11:0] cfg_line_len = 12'd140;
  logic frame_start = 1'b0;
  logic hs = 1'b0, vs = 1'b0, fs = 1'b0;
  logic mst_fs = 1'b0, mst_vs = 1'b0, act = 1'b0;
  logic h_trig, v_trig, fs_po, fs_oe, vs_po, vs_oe, cblank;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vsync_src_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_slave(cfg_slave), .cfg_fs_en(cfg_fs_en), .cfg_h_from_fs(cfg_h_from_fs),
    .cfg_v_from_fs(cfg_v_from_fs), .cfg_fs_pol(cfg_fs_pol), .cfg_vs_pol(cfg_vs_pol),
    .cfg_fs_dir(cfg_fs_dir), .cfg_vs_dir(cfg_vs_dir), .cfg_late_h(cfg_late_h),
    .cfg_blank_pol(cfg_blank_pol), .cfg_line_len(cfg_line_len),
    .frame_start_i(frame_start), .hs_pin_i(hs), .vs_pin_i(vs), .fs_pin_i(fs),
    .mst_fs_i(mst_fs), .mst_vs_i(mst_vs), .active_video_i(act),
    .h_trig_o(h_trig), .v_trig_o(v_trig), .fs_pin_o(fs_po), .fs_oe_o(fs_oe),
    .vs_pin_o(vs_po), .vs_oe_o(vs_oe), .cblank_o(cblank)
  );

  // stimulus {mst_fs, mst_vs, act, fs_pol, vs_pol, blank_pol, fs_dir, vs_dir}
  // expected {fs_pin_o, vs_pin_o, cblank_o, fs_oe_o, vs_oe_o}
  localparam logic [12:0] VEC [6] = '{
    {8'b10100011, 5'b10111},
    {8'b10110100, 5'b00000},
    {8'b01011010, 5'b10010},
    {8'b00001101, 5'b01101},
    {8'b11111111, 5'b00011},
    {8'b01100110, 5'b01010}
  };

  task automatic chk(input string tag, input logic [7:0] actual, input logic [7:0] expected);
    total++;
    if (actual !== expected) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic load_cfg();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // pin: 0 hs, 1 fs, 2 vs; drive at a negedge, pulse expected two negedges later
  task automatic edge_test(input string tag, input int pin, input logic val,
                           input logic exp_h, input logic exp_v);
    case (pin)
      0: hs = val;
      1: fs = val;
      default: vs = val;
    endcase
    @(negedge clk);
    chk({tag, " pre"}, {6'd0, h_trig, v_trig}, 8'd0);
    @(negedge clk);
    chk({tag, " pulse"}, {6'd0, h_trig, v_trig}, {6'd0, exp_h, exp_v});
    @(negedge clk);
    chk({tag, " post"}, {6'd0, h_trig, v_trig}, 8'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", {6'd0, h_trig, v_trig}, 8'd0);

    // master drive, direction and blanking table
    for (int k = 0; k < 6; k++) begin
      {mst_fs, mst_vs, act, cfg_fs_pol, cfg_vs_pol, cfg_blank_pol, cfg_fs_dir, cfg_vs_dir}
        = VEC[k][12:5];
      load_cfg();
      chk($sformatf("R5 R6 R8 vector %0d", k), {3'd0, fs_po, vs_po, cblank, fs_oe, vs_oe},
          {3'd0, VEC[k][4:0]});
    end
    {cfg_fs_pol, cfg_vs_pol, cfg_blank_pol, cfg_fs_dir, cfg_vs_dir} = '0;
    load_cfg();

    // R2 R3 R4 default sources
    edge_test("R2 R3 hs rise", 0, 1'b1, 1'b1, 1'b0);
    edge_test("R2 hs fall ignored", 0, 1'b0, 1'b0, 1'b0);
    edge_test("R4 vs rise", 2, 1'b1, 1'b0, 1'b1);
    edge_test("R4 vs fall ignored", 2, 1'b0, 1'b0, 1'b0);

    // R10 frame sync selected but not enabled
    cfg_h_from_fs = 1'b1; cfg_v_from_fs = 1'b1;
    load_cfg();
    edge_test("R10 fs disabled", 1, 1'b1, 1'b0, 1'b0);
    edge_test("R3 hs kept without fs_en", 0, 1'b1, 1'b1, 1'b0);
    fs = 1'b0; hs = 1'b0;
    repeat (4) @(negedge clk);

    // R3 R4 frame sync as source
    cfg_fs_en = 1'b1;
    load_cfg();
    edge_test("R3 R4 fs rise drives both", 1, 1'b1, 1'b1, 1'b1);
    edge_test("R3 hs ignored when fs source", 0, 1'b1, 1'b0, 1'b0);
    // R5 falling edge polarity
    cfg_fs_pol = 1'b1;
    load_cfg();
    edge_test("R5 fs fall active", 1, 1'b0, 1'b1, 1'b1);
    edge_test("R5 fs rise ignored", 1, 1'b1, 1'b0, 1'b0);
    cfg_v_from_fs = 1'b0; cfg_vs_pol = 1'b1; vs = 1'b1;
    repeat (4) @(negedge clk);
    load_cfg();
    edge_test("R5 vs fall active", 2, 1'b0, 1'b0, 1'b1);
    // R6 pin driven as output ignores its input
    cfg_fs_dir = 1'b1; cfg_vs_dir = 1'b1;
    load_cfg();
    chk("R6 oe set", {6'd0, fs_oe, vs_oe}, 8'd3);
    edge_test("R6 fs output ignored", 1, 1'b0, 1'b0, 1'b0);
    edge_test("R6 vs output ignored", 2, 1'b1, 1'b0, 1'b0);

    // R9 settings wait for the frame boundary
    cfg_h_from_fs = 1'b0; cfg_fs_en = 1'b0; cfg_fs_dir = 1'b0; cfg_vs_dir = 1'b0;
    cfg_fs_pol = 1'b0; cfg_vs_pol = 1'b0; hs = 1'b0; fs = 1'b0; vs = 1'b0;
    load_cfg();
    repeat (4) @(negedge clk);
    cfg_slave = 1'b0;
    @(negedge clk);
    edge_test("R9 change held until frame start", 0, 1'b1, 1'b1, 1'b0);
    load_cfg();
    edge_test("R1 R9 master after frame start", 0, 1'b0, 1'b0, 1'b0);
    edge_test("R1 master ignores hs", 0, 1'b1, 1'b0, 1'b0);

    // R7 advanced horizontal trigger, line length 140 gives a 12 cycle gap
    hs = 1'b0; cfg_slave = 1'b1; cfg_late_h = 1'b1; cfg_line_len = 12'd140;
    do_reset();
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 150; i++) begin
        @(negedge clk);
        if (h_trig !== 1'b0) quiet = 1'b0;
      end
      chk("R7 no trigger before first edge", {7'd0, quiet}, 8'd1);
    end
    hs = 1'b1;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      chk($sformatf("R7 late cycle %0d", i), {7'd0, h_trig},
          {7'd0, (i == 14) || (i == 26)});
      if (i == 4) hs = 1'b0;
      if (i == 12) hs = 1'b1;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

endmodule